// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences a small microcontroller between its running modes and its wait and stop modes. Software writes a 4-bit mode code. A running code (full run or very-low-power run) takes effect at once. The compute code also takes effect at once and parks every peripheral while the core keeps running. Any low-power code is only armed by the write. The armed mode is entered on the next wait-for-interrupt strobe from the core. While the chip sleeps, the controller drives the core, system and bus clock enables, a peripheral-stop request, the clock-generator and full-regulator enables, an SRAM power-down request, an I/O hold, the low-power oscillator enable and the brown-out-detect enable.

Wake-up events are filtered by the mode that is being slept. The shallow modes wake on any enabled interrupt. The leakage modes wake only on a wake-unit event, the NMI pin or the reset pin, and each pin can be removed from that list by its own disable bit. A wake from a shallow or low-leakage mode turns the clocks back on one at a time: bus clock, then system clock, then core clock. The controller then pulses a completion strobe and returns to the running mode it came from. A wake from either very-low-leakage mode raises a reset request instead. That request stays high, along with the I/O hold, until the chip reset arrives.

Top module: `lpm_ctrl`

## Requirements
- R1: Mode codes are run=0, very-low-power run=1, compute=2, wait=3, stop=4, partial stop 1=5, partial stop 2=6, low-leakage stop=7, very-low-leakage stop 1=8 and very-low-leakage stop 0=9. A write of any code from 10 to 15 leaves `cur_mode` unchanged and sets `req_err`. The next accepted write clears `req_err`.
- R2: A write of a code from 3 to 9 only arms that mode, and `cur_mode` stays at the running mode. The armed mode is entered on the first clock edge that sees `wfi` high. A `wfi` while nothing is armed has no effect. An armed mode stays armed across a wake that does not need reset.
- R3: In wait, only the core clock is gated and `periph_stop` stays low. In stop and in low-leakage stop, all three clocks are gated, `periph_stop` is high, and `clkgen_en` and `reg_full_en` are low.
- R4: In partial stop 1, the core, system and bus clocks are gated and `periph_stop` is high. `clkgen_en` stays high and `reg_full_en` keeps its running value, which is high after full run and low after very-low-power run.
- R5: Partial stop 2 matches partial stop 1, except that `bus_clk_en` stays high.
- R6: Compute is entered with a write of code 2, from full run or very-low-power run only. In compute, all clocks run and `periph_stop` is high. A write of 0 or 1 leaves compute and sets the running mode. Any other write is rejected and sets `req_err`.
- R7: Wait, stop and both partial stops wake on `irq_wake`.
- R8: Low-leakage stop and both very-low-leakage stops wake on `wku_evt`, `nmi_pin` or `rst_pin`. They ignore `irq_wake`.
- R9: When `nmi_wake_dis` is set, `nmi_pin` is ignored as a wake source. When `rst_wake_dis` is set, `rst_pin` is ignored as a wake source.
- R10: Both very-low-leakage stops assert `sram_pd` and `io_hold` with all clocks gated. Level 0 also drops `lpo_en` and drives `bod_en` from `bod_cfg`.
- R11: A wake from either very-low-leakage stop raises `rst_req` and keeps it high, together with `io_hold`, until reset. No `wake_done` pulse is given.
- R12: Any other wake turns on the bus clock, then the system clock, then the core clock, one cycle apart, and drops `periph_stop` with the first of them. `wake_done` pulses with the core clock, and on the next cycle `cur_mode` is the running mode again.
- R13: After reset, `cur_mode` is full run, every clock, the clock generator, the regulator, the oscillator and the brown-out detector are enabled, and all other outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for `mode_code` |
| mode_code | input | 4 | Requested mode code |
| wfi | input | 1 | Wait-for-interrupt strobe from the core |
| irq_wake | input | 1 | Any enabled interrupt pending |
| wku_evt | input | 1 | Event from the wake-up unit |
| nmi_pin | input | 1 | NMI pin level |
| rst_pin | input | 1 | Reset pin asserted |
| nmi_wake_dis | input | 1 | Removes the NMI pin from the wake sources |
| rst_wake_dis | input | 1 | Removes the reset pin from the wake sources |
| bod_cfg | input | 1 | Brown-out detect kept on in very-low-leakage stop 0 |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| periph_stop | output | 1 | Stop request to peripherals and other bus masters |
| clkgen_en | output | 1 | Clock generator enable |
| reg_full_en | output | 1 | Regulator full-power enable |
| sram_pd | output | 1 | SRAM power-down request |
| io_hold | output | 1 | I/O state hold |
| lpo_en | output | 1 | Low-power oscillator enable |
| bod_en | output | 1 | Brown-out detect enable |
| rst_req | output | 1 | Reset request for the very-low-leakage exit |
| wake_done | output | 1 | One-cycle pulse when the wake sequence completes |
| cur_mode | output | 4 | Mode now in effect |
| req_err | output | 1 | Last mode write was rejected |

## Verification
Several rules are checked by assertions on every cycle. The core clock only falls after a `wfi`. A rejected code keeps `cur_mode` stable and flags `req_err`. Compute is only reached from a running mode. A reset request only rises after a permitted leakage-mode wake source. `wake_done` only comes after a cycle with the bus clock on and the core clock off, and the I/O hold stays high until reset. Other behaviour needs the bench's scenarios to show it: the exact set of output levels in each sleep mode, the effect of each disable bit, the three-step ungating order, the return to the correct running mode, and the re-entry of a still-armed mode.

// File: rtl/lpm_pkg.sv
// Package lpm_pkg
// Shared mode codes, sequencer phases, the bundle of power outputs and
// small helpers that classify a mode code.
// Assumes: a 4-bit mode code; codes above MODE_LAST are invalid.
package lpm_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] M_RUN     = 4'd0;
    localparam logic [MODE_W-1:0] M_VLPR    = 4'd1;
    localparam logic [MODE_W-1:0] M_COMPUTE = 4'd2;
    localparam logic [MODE_W-1:0] M_WAIT    = 4'd3;
    localparam logic [MODE_W-1:0] M_STOP    = 4'd4;
    localparam logic [MODE_W-1:0] M_PSTOP1  = 4'd5;
    localparam logic [MODE_W-1:0] M_PSTOP2  = 4'd6;
    localparam logic [MODE_W-1:0] M_LLS     = 4'd7;
    localparam logic [MODE_W-1:0] M_VLLS1   = 4'd8;
    localparam logic [MODE_W-1:0] M_VLLS0   = 4'd9;
    localparam logic [MODE_W-1:0] MODE_LAST = M_VLLS0;

    typedef enum logic [2:0] {
        PH_ACTIVE,
        PH_SLEEP,
        PH_UNG_BUS,
        PH_UNG_SYS,
        PH_UNG_CORE,
        PH_RSTREQ
    } phase_e;

    typedef struct packed {
        logic core;
        logic sys;
        logic bus;
        logic pstop;
        logic clkgen;
        logic reg_full;
        logic sram_pd;
        logic io_hold;
        logic lpo;
        logic bod;
    } pwr_out_t;

    // code names a defined mode
    function automatic logic is_valid(input logic [MODE_W-1:0] c);
        return c <= MODE_LAST;
    endfunction

    // code is one of the two running modes
    function automatic logic is_base(input logic [MODE_W-1:0] c);
        return (c == M_RUN) || (c == M_VLPR);
    endfunction

    // code is a wait or stop mode entered on wfi
    function automatic logic is_lowpwr(input logic [MODE_W-1:0] c);
        return (c >= M_WAIT) && (c <= MODE_LAST);
    endfunction

    // code is a leakage mode with restricted wake sources
    function automatic logic is_leak(input logic [MODE_W-1:0] c);
        return (c >= M_LLS) && (c <= MODE_LAST);
    endfunction

    // code is a very-low-leakage mode that exits through reset
    function automatic logic is_vlls(input logic [MODE_W-1:0] c);
        return (c == M_VLLS1) || (c == M_VLLS0);
    endfunction

endpackage

// File: rtl/lpm_req_dec.sv
// Module lpm_req_dec
// Sorts a mode write into exactly one outcome: set the running mode,
// enter compute, leave compute, arm a low-power mode, or reject.
// Assumes: writes only count while the sequencer is in its active phase;
// writes at any other time are dropped without effect.
module lpm_req_dec
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] code,
    input  logic              active,
    input  logic              in_comp,
    output logic              set_base,
    output logic              enter_comp,
    output logic              exit_comp,
    output logic              arm,
    output logic              reject
);

    // Classify the write against the current running context
    always_comb begin
        set_base   = 1'b0;
        enter_comp = 1'b0;
        exit_comp  = 1'b0;
        arm        = 1'b0;
        reject     = 1'b0;
        if (wr && active) begin
            if (!is_valid(code)) begin
                reject = 1'b1;
            end else if (in_comp) begin
                if (is_base(code)) exit_comp = 1'b1;
                else               reject    = 1'b1;
            end else if (is_base(code)) begin
                set_base = 1'b1;
            end else if (code == M_COMPUTE) begin
                enter_comp = 1'b1;
            end else begin
                arm = 1'b1;
            end
        end
    end

    // R1
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_base, enter_comp, exit_comp, arm, reject}));

    // R6
    comp_entry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_comp |-> (!in_comp && active));

endmodule

// File: rtl/lpm_wake_qual.sv
// Module lpm_wake_qual
// Decides whether the present inputs wake the mode that is being slept.
// Shallow modes accept any enabled interrupt; leakage modes accept only
// the wake unit and the two pins, each pin maskable by a disable bit.
// Assumes: inputs are already synchronous to clk.
module lpm_wake_qual
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              irq_wake,
    input  logic              wku_evt,
    input  logic              nmi_pin,
    input  logic              rst_pin,
    input  logic              nmi_dis,
    input  logic              rst_dis,
    output logic              wake
);

    logic leak_src;

    // Sources allowed in the leakage modes
    always_comb begin
        leak_src = wku_evt
                 | (nmi_pin & ~nmi_dis)
                 | (rst_pin & ~rst_dis);
    end

    // Pick the source set that matches the slept mode
    always_comb begin
        if (is_leak(mode))        wake = leak_src;
        else if (is_lowpwr(mode)) wake = irq_wake;
        else                      wake = 1'b0;
    end

    // R8
    leak_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_leak(mode) && irq_wake && !wku_evt && !nmi_pin && !rst_pin) |-> !wake);

    // R9
    masked_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_leak(mode) && nmi_dis && rst_dis && !wku_evt) |-> !wake);

endmodule

// File: rtl/lpm_out_dec.sv
// Module lpm_out_dec
// Turns the sequencer phase, the slept mode and the running context into
// the bundle of power-control levels. During the ungating phases it builds
// the running levels with the not-yet-restored clocks still held off.
// Assumes: compute is never active while a low-power mode is slept.
module lpm_out_dec
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [MODE_W-1:0] lp_mode,
    input  logic              run_base,
    input  logic              in_comp,
    input  logic              bod_cfg,
    output pwr_out_t          pw
);

    pwr_out_t act;
    pwr_out_t slp;

    // Levels while running, in full run, very-low-power run or compute
    always_comb begin
        act          = '0;
        act.core     = 1'b1;
        act.sys      = 1'b1;
        act.bus      = 1'b1;
        act.pstop    = in_comp;
        act.clkgen   = 1'b1;
        act.reg_full = run_base;
        act.lpo      = 1'b1;
        act.bod      = 1'b1;
    end

    // Levels held for each sleep mode
    always_comb begin
        slp       = act;
        slp.core  = 1'b0;
        slp.pstop = 1'b1;
        case (lp_mode)
            M_WAIT: begin
                slp.pstop = 1'b0;
            end
            M_STOP, M_LLS: begin
                slp.sys      = 1'b0;
                slp.bus      = 1'b0;
                slp.clkgen   = 1'b0;
                slp.reg_full = 1'b0;
            end
            M_PSTOP1: begin
                slp.sys = 1'b0;
                slp.bus = 1'b0;
            end
            M_PSTOP2: begin
                slp.sys = 1'b0;
            end
            M_VLLS1, M_VLLS0: begin
                slp.sys      = 1'b0;
                slp.bus      = 1'b0;
                slp.clkgen   = 1'b0;
                slp.reg_full = 1'b0;
                slp.sram_pd  = 1'b1;
                slp.io_hold  = 1'b1;
                if (lp_mode == M_VLLS0) begin
                    slp.lpo = 1'b0;
                    slp.bod = bod_cfg;
                end
            end
            default: begin
                slp = act;
            end
        endcase
    end

    // Select by phase and hold back the clocks not yet restored
    always_comb begin
        case (phase)
            PH_SLEEP, PH_RSTREQ: pw = slp;
            PH_UNG_BUS: begin
                pw      = act;
                pw.core = 1'b0;
                pw.sys  = slp.sys;
            end
            PH_UNG_SYS: begin
                pw      = act;
                pw.core = 1'b0;
            end
            default: pw = act;
        endcase
    end

    // R12
    bus_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_UNG_BUS) |-> (pw.bus && !pw.core && !pw.pstop));

    // R10
    hold_with_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw.sram_pd |-> (pw.io_hold && !pw.core && !pw.sys && !pw.bus));

endmodule

// File: rtl/lpm_ctrl.sv
// Module lpm_ctrl (top)
// Low-power mode entry controller. It holds the running mode, the armed
// low-power target and the compute flag, and it steps a phase machine:
// active -> sleep -> (ungate bus -> ungate sys -> ungate core) -> active,
// or sleep -> reset request for the very-low-leakage modes.
// Assumes: synchronous active-low reset; the reset request is answered by
// a chip reset that drives rst_n low.
module lpm_ctrl
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              wfi,
    input  logic              irq_wake,
    input  logic              wku_evt,
    input  logic              nmi_pin,
    input  logic              rst_pin,
    input  logic              nmi_wake_dis,
    input  logic              rst_wake_dis,
    input  logic              bod_cfg,
    output logic              core_clk_en,
    output logic              sys_clk_en,
    output logic              bus_clk_en,
    output logic              periph_stop,
    output logic              clkgen_en,
    output logic              reg_full_en,
    output logic              sram_pd,
    output logic              io_hold,
    output logic              lpo_en,
    output logic              bod_en,
    output logic              rst_req,
    output logic              wake_done,
    output logic [MODE_W-1:0] cur_mode,
    output logic              req_err
);

    phase_e            phase_q;
    logic [MODE_W-1:0] base_q;
    logic [MODE_W-1:0] tgt_q;
    logic [MODE_W-1:0] lp_mode_q;
    logic              comp_q;
    logic              err_q;

    logic set_base, enter_comp, exit_comp, arm, reject;
    logic wake;
    logic enter_ok;
    pwr_out_t pw;

    lpm_req_dec u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (mode_wr),
        .code       (mode_code),
        .active     (phase_q == PH_ACTIVE),
        .in_comp    (comp_q),
        .set_base   (set_base),
        .enter_comp (enter_comp),
        .exit_comp  (exit_comp),
        .arm        (arm),
        .reject     (reject)
    );

    lpm_wake_qual u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (lp_mode_q),
        .irq_wake (irq_wake),
        .wku_evt  (wku_evt),
        .nmi_pin  (nmi_pin),
        .rst_pin  (rst_pin),
        .nmi_dis  (nmi_wake_dis),
        .rst_dis  (rst_wake_dis),
        .wake     (wake)
    );

    lpm_out_dec u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase_q),
        .lp_mode  (lp_mode_q),
        .run_base (base_q == M_RUN),
        .in_comp  (comp_q),
        .bod_cfg  (bod_cfg),
        .pw       (pw)
    );

    // Sleep entry: wfi from a running mode with a low-power mode armed
    always_comb begin
        enter_ok = (phase_q == PH_ACTIVE) && !comp_q && !mode_wr
                   && wfi && is_lowpwr(tgt_q);
    end

    // Running-context registers updated by accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= M_RUN;
            tgt_q  <= M_RUN;
            comp_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (reject)
                err_q <= 1'b1;
            else if (set_base || enter_comp || exit_comp || arm)
                err_q <= 1'b0;
            if (set_base) begin
                base_q <= mode_code;
                tgt_q  <= M_RUN;
            end
            if (exit_comp) begin
                base_q <= mode_code;
                comp_q <= 1'b0;
            end
            if (enter_comp)
                comp_q <= 1'b1;
            if (arm)
                tgt_q <= mode_code;
        end
    end

    // Phase machine for entry, wake filtering and the ungating walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_ACTIVE;
            lp_mode_q <= M_RUN;
        end else begin
            case (phase_q)
                PH_ACTIVE: begin
                    if (enter_ok) begin
                        phase_q   <= PH_SLEEP;
                        lp_mode_q <= tgt_q;
                    end
                end
                PH_SLEEP: begin
                    if (wake)
                        phase_q <= is_vlls(lp_mode_q) ? PH_RSTREQ : PH_UNG_BUS;
                end
                PH_UNG_BUS:  phase_q <= PH_UNG_SYS;
                PH_UNG_SYS:  phase_q <= PH_UNG_CORE;
                PH_UNG_CORE: phase_q <= PH_ACTIVE;
                PH_RSTREQ:   phase_q <= PH_RSTREQ;
                default:     phase_q <= PH_ACTIVE;
            endcase
        end
    end

    // Drive ports from the registered state
    always_comb begin
        core_clk_en = pw.core;
        sys_clk_en  = pw.sys;
        bus_clk_en  = pw.bus;
        periph_stop = pw.pstop;
        clkgen_en   = pw.clkgen;
        reg_full_en = pw.reg_full;
        sram_pd     = pw.sram_pd;
        io_hold     = pw.io_hold;
        lpo_en      = pw.lpo;
        bod_en      = pw.bod;
        rst_req     = (phase_q == PH_RSTREQ);
        wake_done   = (phase_q == PH_UNG_CORE);
        req_err     = err_q;
        if (phase_q == PH_ACTIVE)
            cur_mode = comp_q ? M_COMPUTE : base_q;
        else
            cur_mode = lp_mode_q;
    end

    // R2
    entry_needs_wfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> $past(wfi));

    // R1
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACTIVE && mode_wr && mode_code > MODE_LAST)
        |=> (req_err && $stable(cur_mode)));

    // R6
    compute_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == M_COMPUTE) |->
        ($past(cur_mode) == M_RUN || $past(cur_mode) == M_VLPR
         || $past(cur_mode) == M_COMPUTE));

    // R11
    rst_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |->
        $past(wku_evt || (nmi_pin && !nmi_wake_dis) || (rst_pin && !rst_wake_dis)));

    // R11
    hold_until_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hold |=> (io_hold && !wake_done));

    // R12
    ungate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (core_clk_en && $past(bus_clk_en) && $past(sys_clk_en)
                       && !$past(core_clk_en)));

endmodule

// File: tb/lpm_ctrl_tb_top.sv
// Bench for lpm_ctrl: directed corner cases, then seeded random mode and
// wake-source sequences checked against expected levels computed here.
module lpm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_code = 4'd0;
    logic       wfi = 1'b0;
    logic       irq_wake = 1'b0;
    logic       wku_evt = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       rst_pin = 1'b0;
    logic       nmi_wake_dis = 1'b0;
    logic       rst_wake_dis = 1'b0;
    logic       bod_cfg = 1'b0;
    logic core_clk_en, sys_clk_en, bus_clk_en, periph_stop, clkgen_en;
    logic reg_full_en, sram_pd, io_hold, lpo_en, bod_en, rst_req, wake_done;
    logic req_err;
    logic [3:0] cur_mode;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lpm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
        .wfi(wfi), .irq_wake(irq_wake), .wku_evt(wku_evt), .nmi_pin(nmi_pin),
        .rst_pin(rst_pin), .nmi_wake_dis(nmi_wake_dis),
        .rst_wake_dis(rst_wake_dis), .bod_cfg(bod_cfg),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
        .bus_clk_en(bus_clk_en), .periph_stop(periph_stop),
        .clkgen_en(clkgen_en), .reg_full_en(reg_full_en), .sram_pd(sram_pd),
        .io_hold(io_hold), .lpo_en(lpo_en), .bod_en(bod_en),
        .rst_req(rst_req), .wake_done(wake_done), .cur_mode(cur_mode),
        .req_err(req_err)
    );

    wire [9:0] obs = {core_clk_en, sys_clk_en, bus_clk_en, periph_stop,
                      clkgen_en, reg_full_en, sram_pd, io_hold, lpo_en, bod_en};

    // Expected levels while running: bit 6 = periph_stop, bit 4 = regulator
    function automatic logic [9:0] exp_active(input int base, input bit comp);
        logic [9:0] v = 10'b1110100011;
        v[6] = comp;
        v[4] = (base == 0);
        return v;
    endfunction

    // Expected levels in each sleep mode
    function automatic logic [9:0] exp_sleep(input int m, input int base, input bit bodc);
        logic [9:0] v;
        case (m)
            3: begin v = 10'b0110100011; v[4] = (base == 0); end
            4: v = 10'b0001000011;
            5: begin v = 10'b0001100011; v[4] = (base == 0); end
            6: begin v = 10'b0011100011; v[4] = (base == 0); end
            7: v = 10'b0001000011;
            8: v = 10'b0001001111;
            default: begin v = 10'b0001001100; v[0] = bodc; end
        endcase
        return v;
    endfunction

    function automatic bit exp_wakes(input int m, input bit irq, input bit wku,
                                     input bit nmi, input bit rp, input bit nd, input bit rd);
        if (m >= 7) return wku || (nmi && !nd) || (rp && !rd);
        return irq;
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            3, 4, 7: return "R3";
            5:       return "R4";
            6:       return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input int code);
        mode_wr = 1'b1;
        mode_code = code[3:0];
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        chk("R13", obs, exp_active(0, 1'b0));
        chk("R13", {rst_req, wake_done, req_err, cur_mode}, 7'd0);
    endtask

    task automatic go_sleep(input int code, input int base);
        wfi = 1'b1;
        tick();
        wfi = 1'b0;
        chk(mode_tag(code), obs, exp_sleep(code, base, bod_cfg));
        chk(mode_tag(code), cur_mode, code);
    endtask

    // Apply one cycle of wake sources and follow the outcome
    task automatic attempt(input int code, input int base, input bit irq, input bit wku,
                           input bit nmi, input bit rp, output bit woke);
        logic [9:0] s;
        string tag;
        s = exp_sleep(code, base, bod_cfg);
        tag = (code < 7) ? "R7" : ((nmi_wake_dis || rst_wake_dis) ? "R9" : "R8");
        irq_wake = irq; wku_evt = wku; nmi_pin = nmi; rst_pin = rp;
        tick();
        irq_wake = 0; wku_evt = 0; nmi_pin = 0; rst_pin = 0;
        woke = exp_wakes(code, irq, wku, nmi, rp, nmi_wake_dis, rst_wake_dis);
        if (!woke) begin
            chk(tag, {obs, rst_req, wake_done}, {s, 2'b00});
        end else if (code >= 8) begin
            chk("R11", {rst_req, wake_done, io_hold}, 3'b101);
            chk("R10", obs, s);
            tick();
            chk("R11", {rst_req, wake_done, io_hold}, 3'b101);
            do_reset();
        end else begin
            chk(tag, rst_req, 1'b0);
            chk("R12", {core_clk_en, sys_clk_en, bus_clk_en, periph_stop, wake_done},
                {1'b0, s[8], 1'b1, 1'b0, 1'b0});
            tick();
            chk("R12", {core_clk_en, sys_clk_en, bus_clk_en, periph_stop, wake_done}, 5'b01100);
            tick();
            chk("R12", {core_clk_en, sys_clk_en, bus_clk_en, periph_stop, wake_done}, 5'b11101);
            tick();
            chk("R12", {wake_done, cur_mode}, {1'b0, base[3:0]});
            chk("R12", obs, exp_active(base, 1'b0));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit woke;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: invalid code rejected, then cleared by a valid write
        do_write(12);
        chk("R1", {req_err, cur_mode}, {1'b1, 4'd0});
        do_write(1);
        chk("R1", {req_err, cur_mode}, {1'b0, 4'd1});

        // R2: wfi with nothing armed does nothing
        wfi = 1'b1; tick(); wfi = 1'b0;
        chk("R2", {obs, cur_mode}, {exp_active(1, 1'b0), 4'd1});

        // R6: compute from very-low-power run, rejection inside, exit
        do_write(2);
        chk("R6", {obs, cur_mode}, {exp_active(1, 1'b1), 4'd2});
        do_write(3);
        chk("R6", {req_err, cur_mode}, {1'b1, 4'd2});
        do_write(0);
        chk("R6", {req_err, cur_mode, periph_stop}, {1'b0, 4'd0, 1'b0});

        // R9/R8: masked pins in low-leakage stop, then a live NMI
        do_write(7);
        chk("R2", cur_mode, 4'd0);
        go_sleep(7, 0);
        nmi_wake_dis = 1'b1; rst_wake_dis = 1'b1;
        attempt(7, 0, 1'b1, 1'b0, 1'b1, 1'b1, woke);
        nmi_wake_dis = 1'b0;
        attempt(7, 0, 1'b0, 1'b0, 1'b1, 1'b0, woke);
        rst_wake_dis = 1'b0;
        chk("R8", woke, 1'b1);

        // R2: armed mode stays armed and re-enters on the next wfi
        go_sleep(7, 0);
        attempt(7, 0, 1'b0, 1'b0, 1'b0, 1'b1, woke);

        // R10: level 0 with brown-out detect kept on
        bod_cfg = 1'b1;
        do_write(9);
        go_sleep(9, 0);
        attempt(9, 0, 1'b0, 1'b1, 1'b0, 1'b0, woke);

        // Random sequences
        for (int it = 0; it < 80; it++) begin
            int base;
            int code;
            base = int'($urandom % 2);
            do_write(base);
            chk("R1", {req_err, cur_mode}, {1'b0, base[3:0]});
            code = int'($urandom % 16);
            bod_cfg = 1'($urandom);
            nmi_wake_dis = 1'($urandom);
            rst_wake_dis = 1'($urandom);
            do_write(code);
            if (code > 9) begin
                chk("R1", {req_err, cur_mode}, {1'b1, base[3:0]});
            end else if (code == 2) begin
                chk("R6", {obs, cur_mode}, {exp_active(base, 1'b1), 4'd2});
                do_write(base);
            end else if (code >= 3) begin
                chk("R2", cur_mode, base);
                go_sleep(code, base);
                woke = 1'b0;
                for (int a = 0; a < 4 && !woke; a++) begin
                    bit irq, wku, nmi, rp;
                    irq = ($urandom % 10) < 3;
                    wku = ($urandom % 10) < 2;
                    nmi = ($urandom % 10) < 3;
                    rp  = ($urandom % 10) < 3;
                    if (a == 3) begin
                        if (code >= 7) wku = 1'b1;
                        else           irq = 1'b1;
                    end
                    attempt(code, base, irq, wku, nmi, rp, woke);
                end
            end
        end
        nmi_wake_dis = 1'b0;
        rst_wake_dis = 1'b0;
        finish_run();
    end

endmodule